// File: doc/BRIEF.md
# Multi-Step Trigger Sequencer

This block is a trigger engine of the kind found in a logic analyzer. It samples a bus of sense inputs on every clock and moves through a small programmable state graph. Each state is called a step. When the configured pattern or multi-cycle sequence has been seen, it emits a one-cycle trigger pulse and raises a sticky interrupt.

Every step carries four signal-match groups and four condition entries. A signal-match group is a masked compare, and a higher-numbered group has higher priority. A condition entry pairs a requirement with an action. The requirement is one of three: a particular group winning, a shared event counter reaching its limit, or the step's cycle timer reaching its terminal value. The action can jump to any step, including an earlier one. It can also fire the trigger and increment or clear one event counter.

Software programs the block through a flat word-addressed register port while the block is disabled, then sets the enable bit. Clearing the enable bit returns the block to its idle state.

Top module: `trig_seq`

## Requirements
- R1: After reset, and whenever the enable bit (bit 0 of register 0x00) is 0, the current step is 0, both event counters and the step timer are 0, the trigger output is low and the interrupt is cleared.
- R2: Group g of step s (mask at 0x10*(s+1)+2g, value at 0x10*(s+1)+2g+1) matches when (sense & mask) == (value & mask). A group whose mask is zero never matches.
- R3: When several groups of the current step match in the same cycle, only the highest-numbered matching group counts as the winner. A group-match condition is met only when its selected group is the winner.
- R4: Condition entry c of step s is at 0x10*(s+1)+8+c. Bits [1:0] select the kind: 0 off, 1 group, 2 counter, 3 timer. When several entries are met in one cycle, only the lowest-numbered one has its action applied.
- R5: The action field [6:4] gives the next step, which may be lower, equal or higher than the current one. A next-step value not below the step count leaves the step unchanged.
- R6: Action bit 8 increments, and bit 9 clears, the event counter chosen by bit 10; clear wins over increment. Counters saturate at 255. A counter condition (kind 2, counter chosen by bits [3:2]) is met when the count is at least the limit written at 0x02+k. Count k reads at 0x04+k.
- R7: The step timer starts at 0 whenever an action is taken and otherwise counts one per cycle, saturating. A timer condition is met in the cycle in which the timer equals the step's limit at 0x10*(s+1)+12.
- R8: An action with bit 7 set drives the trigger output high for exactly the one cycle following the clock edge at which the action is taken, and sets the interrupt at the same edge.
- R9: The interrupt stays high until bit 0 of register 0x01 is written with 1. Writing 0 there leaves it set.
- R10: Writes to the counter limits and the step registers are ignored while enabled. Writes to 0x00 and 0x01 are always accepted.
- R11: Each register reads back the value stored in it. Register 0x01 reads the interrupt in bit 0 and the current step in bits [6:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sense_i | input | SENSE_W | Sense inputs being watched |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data, combinational from address |
| trig_o | output | 1 | One-cycle trigger pulse |
| irq_o | output | 1 | Sticky interrupt request |
| step_o | output | 3 | Current step index |

## Verification
The step timer reaching its limit and a group match on the sense bus can both satisfy conditions of the same step in one cycle. The bench arranges this by entering a step that has a timer entry in slot 0 and a group entry in slot 1. It holds the sense bus idle until the timer is due and then drives the matching pattern on exactly that cycle. The outcome is judged by the step index and the trigger output: the timer entry's jump and pulse must appear, and a second run that matches early must take the group entry's jump with no pulse. The masked compare and the group priority are swept over every sense value of the small configuration.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int DATA_W = 32;
  localparam int STEP_W = 3;

  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_CLIM = 2;
  localparam int A_CNT  = 4;
  localparam int STEP_STRIDE = 16;
  localparam int OFF_COND = 8;
  localparam int OFF_TLIM = 12;

  typedef enum logic [1:0] {
    K_OFF = 2'd0,
    K_GRP = 2'd1,
    K_CNT = 2'd2,
    K_TMR = 2'd3
  } cond_kind_e;

  typedef struct packed {
    logic [20:0] rsvd;
    logic        cnt_idx;
    logic        clr;
    logic        inc;
    logic        fire;
    logic [2:0]  nxt;
    logic [1:0]  sel;
    cond_kind_e  kind;
  } cond_t;

  function automatic int step_addr(input int s, input int off);
    return STEP_STRIDE * (s + 1) + off;
  endfunction
endpackage

// File: rtl/trig_seq_match.sv
module trig_seq_match #(
  parameter int N_GROUPS = 4,
  parameter int SENSE_W  = 8
) (
  input  logic [SENSE_W-1:0]                sense_i,
  input  logic [N_GROUPS-1:0][SENSE_W-1:0]  mask_i,
  input  logic [N_GROUPS-1:0][SENSE_W-1:0]  val_i,
  output logic [N_GROUPS-1:0]               win_oh_o
);
  logic [N_GROUPS-1:0] hit;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign hit[g] = (|mask_i[g]) && (((sense_i ^ val_i[g]) & mask_i[g]) == '0);
  end

  // highest index overrides lower ones
  always_comb begin
    win_oh_o = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (hit[g]) begin
        win_oh_o    = '0;
        win_oh_o[g] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_seq_cond.sv
module trig_seq_cond
  import trig_seq_pkg::*;
#(
  parameter int N_GROUPS = 4,
  parameter int N_COND   = 4,
  parameter int N_CNT    = 2
) (
  input  cond_t [N_COND-1:0]  cond_i,
  input  logic [N_GROUPS-1:0] win_oh_i,
  input  logic [N_CNT-1:0]    cnt_ge_i,
  input  logic                tmr_hit_i,
  output logic                take_o,
  output cond_t               act_o
);
  logic [3:0]        win4;
  logic [3:0]        cnt4;
  logic [N_COND-1:0] met;

  assign win4 = 4'(win_oh_i);
  assign cnt4 = 4'(cnt_ge_i);

  for (genvar c = 0; c < N_COND; c++) begin : g_cond
    always_comb begin
      unique case (cond_i[c].kind)
        K_GRP:   met[c] = win4[cond_i[c].sel];
        K_CNT:   met[c] = cnt4[cond_i[c].sel];
        K_TMR:   met[c] = tmr_hit_i;
        default: met[c] = 1'b0;
      endcase
    end
  end

  // lowest index wins
  always_comb begin
    take_o = 1'b0;
    act_o  = '0;
    for (int c = N_COND - 1; c >= 0; c--) begin
      if (met[c]) begin
        take_o = 1'b1;
        act_o  = cond_i[c];
      end
    end
  end
endmodule

// File: rtl/trig_seq_cfg.sv
module trig_seq_cfg
  import trig_seq_pkg::*;
#(
  parameter int N_STEPS  = 4,
  parameter int N_GROUPS = 4,
  parameter int N_COND   = 4,
  parameter int N_CNT    = 2,
  parameter int SENSE_W  = 8,
  parameter int TMR_W    = 8,
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 8
) (
  input  logic                                           clk_i,
  input  logic                                           rst_ni,
  input  logic                                           we_i,
  input  logic [ADDR_W-1:0]                              addr_i,
  input  logic [DATA_W-1:0]                              wdata_i,
  output logic [DATA_W-1:0]                              rdata_o,
  input  logic                                           trig_set_i,
  input  logic [STEP_W-1:0]                              step_i,
  input  logic [N_CNT-1:0][CNT_W-1:0]                    cnt_i,
  output logic                                           en_o,
  output logic                                           sticky_o,
  output logic [N_STEPS-1:0][N_GROUPS-1:0][SENSE_W-1:0]  mask_o,
  output logic [N_STEPS-1:0][N_GROUPS-1:0][SENSE_W-1:0]  val_o,
  output cond_t [N_STEPS-1:0][N_COND-1:0]                cond_o,
  output logic [N_STEPS-1:0][TMR_W-1:0]                  tlim_o,
  output logic [N_CNT-1:0][CNT_W-1:0]                    clim_o
);
  logic en_q, sticky_q;
  logic wr_ctrl, wr_stat, wr_cfg;

  assign wr_ctrl = we_i && (addr_i == ADDR_W'(A_CTRL));
  assign wr_stat = we_i && (addr_i == ADDR_W'(A_STAT));
  assign wr_cfg  = we_i && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= wdata_i[0];
      if (!en_q) sticky_q <= 1'b0;
      else if (trig_set_i) sticky_q <= 1'b1;
      else if (wr_stat && wdata_i[0]) sticky_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      val_o  <= '0;
      cond_o <= '0;
      tlim_o <= '0;
      clim_o <= '0;
    end else if (wr_cfg) begin
      for (int k = 0; k < N_CNT; k++)
        if (addr_i == ADDR_W'(A_CLIM + k)) clim_o[k] <= wdata_i[CNT_W-1:0];
      for (int s = 0; s < N_STEPS; s++) begin
        for (int g = 0; g < N_GROUPS; g++) begin
          if (addr_i == ADDR_W'(step_addr(s, 2 * g)))
            mask_o[s][g] <= wdata_i[SENSE_W-1:0];
          if (addr_i == ADDR_W'(step_addr(s, 2 * g + 1)))
            val_o[s][g] <= wdata_i[SENSE_W-1:0];
        end
        for (int c = 0; c < N_COND; c++)
          if (addr_i == ADDR_W'(step_addr(s, OFF_COND + c)))
            cond_o[s][c] <= cond_t'(wdata_i);
        if (addr_i == ADDR_W'(step_addr(s, OFF_TLIM)))
          tlim_o[s] <= wdata_i[TMR_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_CTRL)) rdata_o[0] = en_q;
    if (addr_i == ADDR_W'(A_STAT)) begin
      rdata_o[0]          = sticky_q;
      rdata_o[4+:STEP_W]  = step_i;
    end
    for (int k = 0; k < N_CNT; k++) begin
      if (addr_i == ADDR_W'(A_CLIM + k)) rdata_o[CNT_W-1:0] = clim_o[k];
      if (addr_i == ADDR_W'(A_CNT + k))  rdata_o[CNT_W-1:0] = cnt_i[k];
    end
    for (int s = 0; s < N_STEPS; s++) begin
      for (int g = 0; g < N_GROUPS; g++) begin
        if (addr_i == ADDR_W'(step_addr(s, 2 * g)))
          rdata_o[SENSE_W-1:0] = mask_o[s][g];
        if (addr_i == ADDR_W'(step_addr(s, 2 * g + 1)))
          rdata_o[SENSE_W-1:0] = val_o[s][g];
      end
      for (int c = 0; c < N_COND; c++)
        if (addr_i == ADDR_W'(step_addr(s, OFF_COND + c)))
          rdata_o = cond_o[s][c];
      if (addr_i == ADDR_W'(step_addr(s, OFF_TLIM)))
        rdata_o[TMR_W-1:0] = tlim_o[s];
    end
  end

  assign en_o     = en_q;
  assign sticky_o = sticky_q;
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int N_STEPS  = 4,
  parameter int N_GROUPS = 4,
  parameter int N_COND   = 4,
  parameter int N_CNT    = 2,
  parameter int SENSE_W  = 8,
  parameter int TMR_W    = 8,
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SENSE_W-1:0] sense_i,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  output logic               trig_o,
  output logic               irq_o,
  output logic [2:0]         step_o
);
  logic                                          en;
  logic                                          sticky;
  logic [N_STEPS-1:0][N_GROUPS-1:0][SENSE_W-1:0] mask_all, val_all;
  cond_t [N_STEPS-1:0][N_COND-1:0]               cond_all;
  logic [N_STEPS-1:0][TMR_W-1:0]                 tlim_all;
  logic [N_CNT-1:0][CNT_W-1:0]                   clim;

  logic [N_GROUPS-1:0][SENSE_W-1:0] mask_cur, val_cur;
  cond_t [N_COND-1:0]               cond_cur;
  logic [TMR_W-1:0]                 tlim_cur;

  logic [STEP_W-1:0]           step_q;
  logic [TMR_W-1:0]            tmr_q;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [N_CNT-1:0]            cnt_ge;
  logic                        trig_q;
  logic [N_GROUPS-1:0]         win_oh;
  logic                        take;
  cond_t                       act;
  logic                        fire;

  trig_seq_cfg #(
    .N_STEPS(N_STEPS), .N_GROUPS(N_GROUPS), .N_COND(N_COND), .N_CNT(N_CNT),
    .SENSE_W(SENSE_W), .TMR_W(TMR_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .trig_set_i (fire),
    .step_i     (step_q),
    .cnt_i      (cnt_q),
    .en_o       (en),
    .sticky_o   (sticky),
    .mask_o     (mask_all),
    .val_o      (val_all),
    .cond_o     (cond_all),
    .tlim_o     (tlim_all),
    .clim_o     (clim)
  );

  always_comb begin
    mask_cur = '0;
    val_cur  = '0;
    cond_cur = '0;
    tlim_cur = '0;
    for (int s = 0; s < N_STEPS; s++) begin
      if (step_q == STEP_W'(s)) begin
        mask_cur = mask_all[s];
        val_cur  = val_all[s];
        cond_cur = cond_all[s];
        tlim_cur = tlim_all[s];
      end
    end
  end

  trig_seq_match #(.N_GROUPS(N_GROUPS), .SENSE_W(SENSE_W)) u_match (
    .sense_i  (sense_i),
    .mask_i   (mask_cur),
    .val_i    (val_cur),
    .win_oh_o (win_oh)
  );

  for (genvar k = 0; k < N_CNT; k++) begin : g_ge
    assign cnt_ge[k] = cnt_q[k] >= clim[k];
  end

  trig_seq_cond #(.N_GROUPS(N_GROUPS), .N_COND(N_COND), .N_CNT(N_CNT)) u_cond (
    .cond_i    (cond_cur),
    .win_oh_i  (win_oh),
    .cnt_ge_i  (cnt_ge),
    .tmr_hit_i (tmr_q == tlim_cur),
    .take_o    (take),
    .act_o     (act)
  );

  assign fire = en && take && act.fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      tmr_q  <= '0;
      trig_q <= 1'b0;
    end else if (!en) begin
      step_q <= '0;
      tmr_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= fire;
      if (take) begin
        tmr_q <= '0;
        if ({1'b0, act.nxt} < 4'(N_STEPS)) step_q <= act.nxt;
      end else if (tmr_q != '1) begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    logic sel_k;
    assign sel_k = take && (act.cnt_idx == 1'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      cnt_q[k] <= '0;
      else if (!en)                     cnt_q[k] <= '0;
      else if (sel_k && act.clr)        cnt_q[k] <= '0;
      else if (sel_k && act.inc && cnt_q[k] != '1) cnt_q[k] <= cnt_q[k] + 1'b1;
    end
  end

  assign trig_o = trig_q;
  assign irq_o  = sticky;
  assign step_o = step_q;
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int N_STEPS = 4,
  parameter int ADDR_W  = 8,
  parameter int TMR_W   = 8,
  parameter int CNT_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wbit0_i,
  input logic              trig_i,
  input logic              irq_i,
  input logic [2:0]        step_i,
  input logic [TMR_W-1:0]  tmr_i,
  input logic [CNT_W-1:0]  cnt0_i
);
  // R1
  dis_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (step_i == '0) && !trig_i && !irq_i && (tmr_i == '0) && (cnt0_i == '0));

  // R8
  trig_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |-> irq_i);

  // R5
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, step_i} < 4'(N_STEPS));

  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_i) |-> $past(!en_i || (we_i && addr_i == ADDR_W'(1) && wbit0_i)));

  // R7
  tmr_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i != $past(step_i)) |-> (tmr_i == '0));

  // R6
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt0_i == '1) |=> ((cnt0_i == '1) || (cnt0_i == '0)));
endmodule

bind trig_seq trig_seq_chk #(
  .N_STEPS(N_STEPS), .ADDR_W(ADDR_W), .TMR_W(TMR_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en),
  .we_i    (cfg_we_i),
  .addr_i  (cfg_addr_i),
  .wbit0_i (cfg_wdata_i[0]),
  .trig_i  (trig_o),
  .irq_i   (irq_o),
  .step_i  (step_o),
  .tmr_i   (tmr_q),
  .cnt0_i  (cnt_q[0])
);

// File: tb/trig_seq_tb.sv
`timescale 1ns/1ps
module trig_seq_tb;
  localparam int SW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [SW-1:0] sense = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        trig, irq;
  logic [2:0]  step;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  trig_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sense_i(sense),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .trig_o(trig), .irq_o(irq), .step_o(step)
  );

  function automatic logic [7:0] sa(input int s, input int off);
    return 8'(16 * (s + 1) + off);
  endfunction

  function automatic logic [31:0] mk(input int kind, input int sel, input int nxt,
                                     input int fire, input int inc, input int clr, input int idx);
    return 32'((kind & 3) | ((sel & 3) << 2) | ((nxt & 7) << 4) | ((fire & 1) << 7)
             | ((inc & 1) << 8) | ((clr & 1) << 9) | ((idx & 1) << 10));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick(1);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
    addr = '0;
  endtask

  task automatic clean();
    wr(8'd0, 0);
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) wr(sa(s, 8 + c), 0);
      for (int g = 0; g < 8; g++) wr(sa(s, g), 0);
    end
    sense = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    tick(3);
    #0.5;
    // R1 reset state
    check("R1 trig", 32'(trig), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 step", 32'(step), 0);
    rst_n = 1'b1;
    tick(1);
    rd(8'd0, r); check("R11 ctrl", r, 0);

    // R2 masked compare sweep
    wr(sa(0, 0), 32'h5A); wr(sa(0, 1), 32'h48);
    wr(sa(0, 8), mk(1, 0, 0, 1, 0, 0, 0));
    rd(sa(0, 0), r); check("R11 mask", r, 32'h5A);
    rd(sa(0, 8), r); check("R11 cond", r, mk(1, 0, 0, 1, 0, 0, 0));
    wr(8'd0, 1);
    for (int v = 0; v < 256; v++) begin
      sense = 8'(v);
      tick(1);
      check("R2 match", 32'(trig), 32'(((v & 8'h5A) == (8'h48 & 8'h5A)) ? 1 : 0));
    end
    wr(8'd0, 0);
    wr(sa(0, 0), 0); wr(sa(0, 1), 0);
    wr(8'd0, 1);
    for (int v = 0; v < 256; v += 17) begin
      sense = 8'(v);
      tick(1);
      check("R2 zero mask", 32'(trig), 0);
    end

    // R3 group priority sweep
    clean();
    for (int g = 0; g < 4; g++) begin
      wr(sa(0, 2 * g), 32'(1 << g)); wr(sa(0, 2 * g + 1), 32'(1 << g));
    end
    wr(sa(0, 8), mk(1, 1, 0, 1, 0, 0, 0));
    wr(8'd0, 1);
    for (int v = 0; v < 16; v++) begin
      sense = 8'(v);
      tick(1);
      check("R3 priority", 32'(trig), 32'((v[1] && !v[2] && !v[3]) ? 1 : 0));
    end

    // R4 lowest entry wins, R5 forward and backward jump
    clean();
    wr(sa(0, 0), 1); wr(sa(0, 1), 1);
    wr(sa(0, 8), mk(1, 0, 2, 0, 0, 0, 0));
    wr(sa(0, 9), mk(1, 0, 1, 1, 0, 0, 0));
    wr(sa(2, 0), 1); wr(sa(2, 1), 1);
    wr(sa(2, 8), mk(1, 0, 0, 1, 0, 0, 0));
    wr(sa(1, 0), 1); wr(sa(1, 1), 1);
    wr(sa(1, 8), mk(1, 0, 6, 0, 0, 0, 0));
    wr(8'd0, 1);
    sense = 8'h01;
    tick(1);
    check("R4 step", 32'(step), 2);
    check("R4 no trig", 32'(trig), 0);
    rd(8'd1, r); check("R11 status", r, 32'h20);
    tick(1);
    check("R5 back step", 32'(step), 0);
    check("R5 back trig", 32'(trig), 1);
    wr(8'd0, 0);
    wr(sa(0, 8), mk(1, 0, 1, 0, 0, 0, 0));
    wr(8'd0, 1);
    tick(1);
    check("R5 to 1", 32'(step), 1);
    tick(2);
    check("R5 out of range", 32'(step), 1);

    // R6 counting to three, clear, saturation
    clean();
    wr(8'd2, 3);
    wr(sa(0, 0), 1); wr(sa(0, 1), 1);
    wr(sa(0, 8), mk(2, 0, 0, 1, 0, 1, 0));
    wr(sa(0, 9), mk(1, 0, 0, 0, 1, 0, 0));
    wr(8'd0, 1);
    for (int p = 0; p < 3; p++) begin
      sense = 8'h01; tick(1);
      check("R6 no early trig", 32'(trig), 0);
      sense = 8'h00; if (p < 2) tick(1);
    end
    rd(8'd4, r); check("R6 count", r, 3);
    tick(1);
    check("R6 count trig", 32'(trig), 1);
    rd(8'd4, r); check("R6 cleared", r, 0);
    tick(1);
    check("R8 pulse width", 32'(trig), 0);
    wr(8'd0, 0);
    wr(sa(0, 8), mk(1, 0, 0, 0, 1, 0, 1));
    wr(sa(0, 9), 0);
    wr(8'd0, 1);
    sense = 8'h01;
    tick(300);
    rd(8'd5, r); check("R6 saturate", r, 255);

    // R7 timer
    clean();
    wr(sa(0, 0), 1); wr(sa(0, 1), 1);
    wr(sa(0, 8), mk(1, 0, 1, 0, 0, 0, 0));
    wr(sa(1, 8), mk(3, 0, 0, 1, 0, 0, 0));
    wr(sa(1, 12), 5);
    wr(8'd0, 1);
    sense = 8'h01; tick(1); sense = 8'h00;
    check("R7 entered", 32'(step), 1);
    for (int i = 0; i < 5; i++) begin
      tick(1);
      check("R7 wait", 32'(trig), 0);
    end
    tick(1);
    check("R7 expiry trig", 32'(trig), 1);
    check("R7 expiry step", 32'(step), 0);

    // R4/R7 timer and match together
    clean();
    wr(sa(0, 0), 1); wr(sa(0, 1), 1);
    wr(sa(0, 8), mk(1, 0, 1, 0, 0, 0, 0));
    wr(sa(1, 0), 2); wr(sa(1, 1), 2);
    wr(sa(1, 8), mk(3, 0, 0, 1, 0, 0, 0));
    wr(sa(1, 9), mk(1, 0, 2, 0, 0, 0, 0));
    wr(sa(1, 12), 3);
    wr(8'd0, 1);
    sense = 8'h01; tick(1); sense = 8'h00;
    tick(3);
    sense = 8'h02; tick(1); sense = 8'h00;
    check("R4 collide step", 32'(step), 0);
    check("R4 collide trig", 32'(trig), 1);
    sense = 8'h01; tick(1);
    sense = 8'h02; tick(1); sense = 8'h00;
    check("R7 early match step", 32'(step), 2);
    check("R7 early match trig", 32'(trig), 0);

    // R9 sticky interrupt
    check("R9 irq set", 32'(irq), 1);
    wr(8'd1, 0);
    check("R9 write 0", 32'(irq), 1);
    wr(8'd1, 1);
    check("R9 write 1", 32'(irq), 0);

    // R10 lock while enabled
    wr(sa(0, 0), 32'hFF);
    wr(8'd2, 9);
    wr(8'd0, 0);
    rd(sa(0, 0), r); check("R10 mask locked", r, 1);
    rd(8'd2, r); check("R10 limit locked", r, 3);

    // R1 disable clears
    wr(8'd0, 1);
    sense = 8'h01; tick(1); sense = 8'h00; tick(3);
    sense = 8'h02; tick(1); sense = 8'h00;
    check("R1 pre irq", 32'(irq), 1);
    sense = 8'h01; tick(1);
    wr(8'd0, 0);
    tick(1);
    check("R1 dis step", 32'(step), 0);
    check("R1 dis irq", 32'(irq), 0);
    check("R1 dis trig", 32'(trig), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule